// File: doc/BRIEF.md
# Working Register Bank with Paired Address Pointers

This block holds the general working registers of a small eight-bit processor core: thirty-two byte-wide registers, reset to zero. Two operand selectors read any register combinationally, and one byte write port stores a result at the clock edge. A second, narrower selector serves instructions that carry a constant. Its four-bit field can only name the upper sixteen registers. The same registers also sit at the bottom of the data address space, so a load or store to an address below 0x20 reaches a register instead of memory.

The six highest registers are paired into three sixteen-bit address pointers. A pointer can be read or written as a whole word, and it stays coherent with byte writes to its halves. A pointer update input steps a pointer up or down by one and returns the address the memory access must use. The instruction decoder, the ALU and the memory beyond the register window sit outside this block.

Top module: `wreg_bank`

## Requirements
- R1: Reset, synchronous and active high, clears all 32 registers to zero. After reset every read port and every pointer view returns zero.
- R2: Both operand read ports return the value stored before the current edge. A byte written at an edge is visible on the following cycle and never in the same cycle.
- R3: The constant-operand selector `imm_sel` (4 bits) addresses register 16 + `imm_sel`, for both reading (`imm_rdata`) and writing (`imm_we`).
- R4: With `ds_en` high and `ds_addr` below 0x20, `ds_rdata` returns register `ds_addr`, and a write with `ds_we` stores `ds_wdata` into that register.
- R5: With `ds_en` high and `ds_addr` at 0x20 or above, `ds_oow` is 1, `ds_rdata` is 0 and no register changes.
- R6: Pointer select codes are 0 = pair 27:26, 1 = pair 29:28, 2 = pair 31:30, and 3 = none. In each pair the even register is the low byte and the odd register is the high byte. Reading with code 3 returns 0.
- R7: A pointer write (`ptr_we`) replaces both bytes of the selected pair at one edge. Byte writes to registers 26 to 31 show through the pointer view on the next cycle.
- R8: Post-increment (`upd_mode` = 0) returns the current pointer on `upd_addr` and stores pointer + 1, wrapping 0xFFFF to 0x0000.
- R9: Pre-decrement (`upd_mode` = 1) returns pointer − 1 on `upd_addr` and stores that value, wrapping 0x0000 to 0xFFFF.
- R10: Only one byte write is taken per cycle, by priority: register port first, then constant-operand port, then data-space port. A taken byte write beats a pointer write for its own byte, and the other byte of the pair takes the pointer value.
- R11: A pointer write beats a pointer update of the same cycle. A pointer write or update with select code 3 changes nothing, and an update with code 3 returns 0 on `upd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_sel | input | 5 | First operand register select |
| ra_data | output | 8 | First operand value |
| rb_sel | input | 5 | Second operand register select |
| rb_data | output | 8 | Second operand value |
| wr_en | input | 1 | Register-port write enable |
| wr_sel | input | 5 | Register-port write target |
| wr_data | input | 8 | Register-port write value |
| imm_sel | input | 4 | Constant-operand register field (upper half) |
| imm_rdata | output | 8 | Value of register 16 + imm_sel |
| imm_we | input | 1 | Constant-operand write enable |
| imm_wdata | input | 8 | Constant-operand write value |
| ds_en | input | 1 | Data-space access valid |
| ds_we | input | 1 | Data-space write |
| ds_addr | input | 16 | Data-space address |
| ds_wdata | input | 8 | Data-space write value |
| ds_rdata | output | 8 | Data-space read value inside the window |
| ds_oow | output | 1 | Access lies outside the register window |
| ptr_we | input | 1 | Whole-pointer write enable |
| ptr_sel | input | 2 | Pointer written |
| ptr_wdata | input | 16 | Pointer write value |
| ptr_rd_sel | input | 2 | Pointer viewed |
| ptr_rdata | output | 16 | Pointer view value |
| upd_en | input | 1 | Pointer step enable |
| upd_sel | input | 2 | Pointer stepped |
| upd_mode | input | 1 | 0 post-increment, 1 pre-decrement |
| upd_addr | output | 16 | Address to use for the stepped access |

## Verification
The assertions check on every cycle the relations that hold between ports. The constant-operand view and the data-space view must agree with an operand read of the same register. A register-port write must appear on the next cycle's read. A whole-pointer write with no competing byte write must show through the pointer view. Both step modes must return the right address, and out-of-window reads must return zero. The bench scenarios alone show the states that depend on history: reset clearing, the absence of bypass, the wrap at both ends of the pointer range, the byte-against-pointer priority inside a pair, and write attempts that must leave state untouched.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  localparam int NUM_PTR   = 3;
  localparam int PTR_SEL_W = 2;

  typedef enum logic [PTR_SEL_W-1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_id_e;

  typedef enum logic {
    UPD_POSTINC = 1'b0,
    UPD_PREDEC  = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/wreg_store.sv
module wreg_store #(
  parameter int NREG     = 32,
  parameter int DW       = 8,
  parameter int PTR_BASE = 26,
  parameter int NPTR     = 3,
  parameter int NRD      = 4,
  parameter int PSW      = 2,
  localparam int SELW    = $clog2(NREG),
  localparam int PW      = 2 * DW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bw_en,
  input  logic [SELW-1:0]           bw_idx,
  input  logic [DW-1:0]             bw_data,
  input  logic                      pw_en,
  input  logic [PSW-1:0]            pw_sel,
  input  logic [PW-1:0]             pw_data,
  input  logic [NRD-1:0][SELW-1:0]  rd_sel,
  output logic [NRD-1:0][DW-1:0]    rd_data,
  output logic [NPTR-1:0][PW-1:0]   ptr_q
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int  OFS     = i - PTR_BASE;
    localparam bit  IN_PAIR = (OFS >= 0) && (OFS < 2 * NPTR);
    logic [DW-1:0] q_r;
    logic          byte_hit;
    assign byte_hit = bw_en && (bw_idx == SELW'(i));
    assign regs[i]  = q_r;

    if (IN_PAIR) begin : g_pair
      localparam int PIDX = OFS / 2;
      localparam bit HI   = (OFS % 2) == 1;
      always_ff @(posedge clk) begin
        if (rst)
          q_r <= '0;
        else if (byte_hit)
          q_r <= bw_data;
        else if (pw_en && pw_sel == PSW'(PIDX))
          q_r <= HI ? pw_data[PW-1:DW] : pw_data[DW-1:0];
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          q_r <= '0;
        else if (byte_hit)
          q_r <= bw_data;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = regs[rd_sel[r]];
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptr_q[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end
endmodule

// File: rtl/wreg_wr_arb.sv
module wreg_wr_arb #(
  parameter int SELW = 5,
  parameter int DW   = 8
) (
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            imm_we,
  input  logic [SELW-2:0] imm_sel,
  input  logic [DW-1:0]   imm_data,
  input  logic            ds_we,
  input  logic [SELW-1:0] ds_idx,
  input  logic [DW-1:0]   ds_data,
  output logic            bw_en,
  output logic [SELW-1:0] bw_idx,
  output logic [DW-1:0]   bw_data
);
  always_comb begin
    bw_en   = 1'b1;
    bw_idx  = '0;
    bw_data = '0;
    if (wr_en) begin
      bw_idx  = wr_sel;
      bw_data = wr_data;
    end else if (imm_we) begin
      bw_idx  = {1'b1, imm_sel};
      bw_data = imm_data;
    end else if (ds_we) begin
      bw_idx  = ds_idx;
      bw_data = ds_data;
    end else begin
      bw_en   = 1'b0;
    end
  end
endmodule

// File: rtl/wreg_dspace_dec.sv
module wreg_dspace_dec #(
  parameter int AW   = 16,
  parameter int SELW = 5
) (
  input  logic            ds_en,
  input  logic            ds_we,
  input  logic [AW-1:0]   ds_addr,
  output logic            in_win,
  output logic            oow,
  output logic            byte_we,
  output logic [SELW-1:0] idx
);
  logic upper_zero;
  assign upper_zero = (ds_addr[AW-1:SELW] == '0);
  assign in_win     = ds_en && upper_zero;
  assign oow        = ds_en && !upper_zero;
  assign byte_we    = in_win && ds_we;
  assign idx        = ds_addr[SELW-1:0];
endmodule

// File: rtl/wreg_ptr_unit.sv
module wreg_ptr_unit
  import wreg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NPTR = NUM_PTR,
  localparam int PW  = 2 * DW,
  localparam int PSW = PTR_SEL_W
) (
  input  logic [NPTR-1:0][PW-1:0] ptr_q,
  input  logic                    ptr_we,
  input  logic [PSW-1:0]          ptr_sel,
  input  logic [PW-1:0]           ptr_wdata,
  input  logic                    upd_en,
  input  logic [PSW-1:0]          upd_sel,
  input  logic                    upd_mode,
  input  logic [PSW-1:0]          rd_sel,
  output logic [PW-1:0]           rd_data,
  output logic [PW-1:0]           upd_addr,
  output logic                    pw_en,
  output logic [PSW-1:0]          pw_sel,
  output logic [PW-1:0]           pw_data
);
  logic [PW-1:0] cur, cur_inc, cur_dec;
  logic          cur_ok, wr_ok, take_wr, take_upd;
  upd_mode_e     mode;

  always_comb begin
    rd_data = '0;
    cur     = '0;
    cur_ok  = 1'b0;
    wr_ok   = 1'b0;
    for (int k = 0; k < NPTR; k++) begin
      if (rd_sel == PSW'(k))  rd_data = ptr_q[k];
      if (upd_sel == PSW'(k)) begin
        cur    = ptr_q[k];
        cur_ok = 1'b1;
      end
      if (ptr_sel == PSW'(k)) wr_ok = 1'b1;
    end
  end

  assign mode     = upd_mode_e'(upd_mode);
  assign cur_inc  = cur + PW'(1);
  assign cur_dec  = cur - PW'(1);
  assign take_wr  = ptr_we && wr_ok;
  assign take_upd = upd_en && cur_ok;

  assign upd_addr = !take_upd ? '0 : (mode == UPD_PREDEC) ? cur_dec : cur;
  assign pw_en    = take_wr || take_upd;
  assign pw_sel   = take_wr ? ptr_sel : upd_sel;
  assign pw_data  = take_wr ? ptr_wdata :
                    (mode == UPD_PREDEC) ? cur_dec : cur_inc;
endmodule

// File: rtl/wreg_bank.sv
module wreg_bank
  import wreg_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int PTR_BASE = 26,
  localparam int SELW    = $clog2(NREG),
  localparam int IMMW    = SELW - 1,
  localparam int PW      = 2 * DW,
  localparam int PSW     = PTR_SEL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] ra_sel,
  output logic [DW-1:0]   ra_data,
  input  logic [SELW-1:0] rb_sel,
  output logic [DW-1:0]   rb_data,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [IMMW-1:0] imm_sel,
  output logic [DW-1:0]   imm_rdata,
  input  logic            imm_we,
  input  logic [DW-1:0]   imm_wdata,
  input  logic            ds_en,
  input  logic            ds_we,
  input  logic [AW-1:0]   ds_addr,
  input  logic [DW-1:0]   ds_wdata,
  output logic [DW-1:0]   ds_rdata,
  output logic            ds_oow,
  input  logic            ptr_we,
  input  logic [PSW-1:0]  ptr_sel,
  input  logic [PW-1:0]   ptr_wdata,
  input  logic [PSW-1:0]  ptr_rd_sel,
  output logic [PW-1:0]   ptr_rdata,
  input  logic            upd_en,
  input  logic [PSW-1:0]  upd_sel,
  input  logic            upd_mode,
  output logic [PW-1:0]   upd_addr
);
  localparam int NRD    = 4;
  localparam int RD_A   = 0;
  localparam int RD_B   = 1;
  localparam int RD_IMM = 2;
  localparam int RD_DS  = 3;

  logic [NRD-1:0][SELW-1:0] rd_sel;
  logic [NRD-1:0][DW-1:0]   rd_data;
  logic [NUM_PTR-1:0][PW-1:0] ptr_q;

  logic            ds_in_win, ds_byte_we;
  logic [SELW-1:0] ds_idx;
  logic            bw_en;
  logic [SELW-1:0] bw_idx;
  logic [DW-1:0]   bw_data;
  logic            pw_en;
  logic [PSW-1:0]  pw_sel;
  logic [PW-1:0]   pw_data;

  assign rd_sel[RD_A]   = ra_sel;
  assign rd_sel[RD_B]   = rb_sel;
  assign rd_sel[RD_IMM] = {1'b1, imm_sel};
  assign rd_sel[RD_DS]  = ds_idx;

  wreg_dspace_dec #(.AW(AW), .SELW(SELW)) u_dec (
    .ds_en   (ds_en),
    .ds_we   (ds_we),
    .ds_addr (ds_addr),
    .in_win  (ds_in_win),
    .oow     (ds_oow),
    .byte_we (ds_byte_we),
    .idx     (ds_idx)
  );

  wreg_wr_arb #(.SELW(SELW), .DW(DW)) u_arb (
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .imm_we   (imm_we),
    .imm_sel  (imm_sel),
    .imm_data (imm_wdata),
    .ds_we    (ds_byte_we),
    .ds_idx   (ds_idx),
    .ds_data  (ds_wdata),
    .bw_en    (bw_en),
    .bw_idx   (bw_idx),
    .bw_data  (bw_data)
  );

  wreg_ptr_unit #(.DW(DW), .NPTR(NUM_PTR)) u_ptr (
    .ptr_q     (ptr_q),
    .ptr_we    (ptr_we),
    .ptr_sel   (ptr_sel),
    .ptr_wdata (ptr_wdata),
    .upd_en    (upd_en),
    .upd_sel   (upd_sel),
    .upd_mode  (upd_mode),
    .rd_sel    (ptr_rd_sel),
    .rd_data   (ptr_rdata),
    .upd_addr  (upd_addr),
    .pw_en     (pw_en),
    .pw_sel    (pw_sel),
    .pw_data   (pw_data)
  );

  wreg_store #(
    .NREG(NREG), .DW(DW), .PTR_BASE(PTR_BASE),
    .NPTR(NUM_PTR), .NRD(NRD), .PSW(PSW)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .bw_en   (bw_en),
    .bw_idx  (bw_idx),
    .bw_data (bw_data),
    .pw_en   (pw_en),
    .pw_sel  (pw_sel),
    .pw_data (pw_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .ptr_q   (ptr_q)
  );

  assign ra_data   = rd_data[RD_A];
  assign rb_data   = rd_data[RD_B];
  assign imm_rdata = rd_data[RD_IMM];
  assign ds_rdata  = ds_in_win ? rd_data[RD_DS] : '0;
endmodule

// File: rtl/wreg_bank_chk.sv
module wreg_bank_chk #(
  parameter int SELW = 5,
  parameter int DW   = 8,
  parameter int AW   = 16,
  parameter int PW   = 16,
  parameter int PSW  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [SELW-1:0] ra_sel,
  input logic [DW-1:0]   ra_data,
  input logic [DW-1:0]   rb_data,
  input logic            wr_en,
  input logic [SELW-1:0] wr_sel,
  input logic [DW-1:0]   wr_data,
  input logic [SELW-2:0] imm_sel,
  input logic [DW-1:0]   imm_rdata,
  input logic            imm_we,
  input logic            ds_en,
  input logic            ds_we,
  input logic [AW-1:0]   ds_addr,
  input logic [DW-1:0]   ds_rdata,
  input logic            ds_oow,
  input logic            ptr_we,
  input logic [PSW-1:0]  ptr_sel,
  input logic [PW-1:0]   ptr_wdata,
  input logic [PSW-1:0]  ptr_rd_sel,
  input logic [PW-1:0]   ptr_rdata,
  input logic            upd_en,
  input logic [PSW-1:0]  upd_sel,
  input logic            upd_mode,
  input logic [PW-1:0]   upd_addr
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ra_data == '0 && rb_data == '0 && ptr_rdata == '0));

  p_next_cycle_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && ra_sel == $past(wr_sel))
      |-> ra_data == $past(wr_data));

  p_upper_half_r3: assert property (@(posedge clk) disable iff (rst)
    (ra_sel == {1'b1, imm_sel}) |-> imm_rdata == ra_data);

  p_window_read_r4: assert property (@(posedge clk) disable iff (rst)
    (ds_en && !ds_oow && ra_sel == ds_addr[SELW-1:0]) |-> ds_rdata == ra_data);

  p_outside_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ds_oow |-> ds_rdata == '0);

  p_pair_write_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ptr_we) && $past(ptr_sel) != 2'd3 &&
     !$past(wr_en) && !$past(imm_we) && !$past(ds_en && ds_we) &&
     ptr_rd_sel == $past(ptr_sel))
      |-> ptr_rdata == $past(ptr_wdata));

  p_postinc_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_mode && upd_sel != 2'd3 && ptr_rd_sel == upd_sel)
      |-> upd_addr == ptr_rdata);

  p_predec_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_mode && upd_sel != 2'd3 && ptr_rd_sel == upd_sel)
      |-> upd_addr == ptr_rdata - PW'(1));

  p_none_sel_r11: assert property (@(posedge clk) disable iff (rst)
    (upd_sel == 2'd3) |-> upd_addr == '0);
endmodule

bind wreg_bank wreg_bank_chk #(
  .SELW(SELW), .DW(DW), .AW(AW), .PW(PW), .PSW(PSW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ra_sel     (ra_sel),
  .ra_data    (ra_data),
  .rb_data    (rb_data),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .imm_sel    (imm_sel),
  .imm_rdata  (imm_rdata),
  .imm_we     (imm_we),
  .ds_en      (ds_en),
  .ds_we      (ds_we),
  .ds_addr    (ds_addr),
  .ds_rdata   (ds_rdata),
  .ds_oow     (ds_oow),
  .ptr_we     (ptr_we),
  .ptr_sel    (ptr_sel),
  .ptr_wdata  (ptr_wdata),
  .ptr_rd_sel (ptr_rd_sel),
  .ptr_rdata  (ptr_rdata),
  .upd_en     (upd_en),
  .upd_sel    (upd_sel),
  .upd_mode   (upd_mode),
  .upd_addr   (upd_addr)
);

// File: tb/wreg_bank_bench.sv
`timescale 1ns/1ps
module wreg_bank_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  ra_sel, rb_sel, wr_sel;
  logic [7:0]  ra_data, rb_data, wr_data, imm_rdata, imm_wdata, ds_wdata, ds_rdata;
  logic        wr_en, imm_we, ds_en, ds_we, ds_oow, ptr_we, upd_en, upd_mode;
  logic [3:0]  imm_sel;
  logic [15:0] ds_addr, ptr_wdata, ptr_rdata, upd_addr;
  logic [1:0]  ptr_sel, ptr_rd_sel, upd_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wreg_bank u_wreg_bank (
    .clk(clk), .rst(rst),
    .ra_sel(ra_sel), .ra_data(ra_data), .rb_sel(rb_sel), .rb_data(rb_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .imm_sel(imm_sel), .imm_rdata(imm_rdata), .imm_we(imm_we), .imm_wdata(imm_wdata),
    .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata), .ds_oow(ds_oow),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_rd_sel(ptr_rd_sel), .ptr_rdata(ptr_rdata),
    .upd_en(upd_en), .upd_sel(upd_sel), .upd_mode(upd_mode), .upd_addr(upd_addr)
  );

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_IW = 3'd2, OP_IR = 3'd3,
                         OP_DW = 3'd4, OP_DR = 3'd5, OP_PW = 3'd6, OP_PR = 3'd7;
  localparam int NV = 22;
  // {op, sel/addr-low, data, expected}; for data-space ops expected bit 8 is ds_oow
  localparam logic [42:0] VEC [NV] = '{
    {OP_WR, 8'd3,   16'h005A, 16'h0000},
    {OP_RD, 8'd3,   16'h0000, 16'h005A},
    {OP_WR, 8'd31,  16'h00C3, 16'h0000},
    {OP_RD, 8'd31,  16'h0000, 16'h00C3},
    {OP_IW, 8'd0,   16'h0011, 16'h0000},
    {OP_RD, 8'd16,  16'h0000, 16'h0011},
    {OP_IR, 8'd15,  16'h0000, 16'h00C3},
    {OP_DW, 8'h05,  16'h0077, 16'h0000},
    {OP_RD, 8'd5,   16'h0000, 16'h0077},
    {OP_DR, 8'h03,  16'h0000, 16'h005A},
    {OP_DW, 8'h20,  16'h00EE, 16'h0100},
    {OP_DR, 8'h20,  16'h0000, 16'h0100},
    {OP_RD, 8'd0,   16'h0000, 16'h0000},
    {OP_PW, 8'd0,   16'h1234, 16'h0000},
    {OP_RD, 8'd26,  16'h0000, 16'h0034},
    {OP_RD, 8'd27,  16'h0000, 16'h0012},
    {OP_PR, 8'd0,   16'h0000, 16'h1234},
    {OP_WR, 8'd28,  16'h00CD, 16'h0000},
    {OP_WR, 8'd29,  16'h00AB, 16'h0000},
    {OP_PR, 8'd1,   16'h0000, 16'hABCD},
    {OP_DR, 8'h1A,  16'h0000, 16'h0034},
    {OP_IR, 8'd11,  16'h0000, 16'h0012}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = '0; wr_data = '0; ra_sel = '0; rb_sel = '0;
    imm_we = 0; imm_sel = '0; imm_wdata = '0;
    ds_en = 0; ds_we = 0; ds_addr = '0; ds_wdata = '0;
    ptr_we = 0; ptr_sel = 2'd3; ptr_wdata = '0; ptr_rd_sel = 2'd3;
    upd_en = 0; upd_sel = 2'd3; upd_mode = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_reg(input string req, input logic [4:0] r, input logic [7:0] exp);
    ra_sel = r; rb_sel = r; #1;
    chk(req, {8'h00, ra_data}, {8'h00, exp});
    chk(req, {8'h00, rb_data}, {8'h00, exp});
  endtask

  task automatic rd_ptr(input string req, input logic [1:0] p, input logic [15:0] exp);
    ptr_rd_sel = p; #1;
    chk(req, ptr_rdata, exp);
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: all registers and pointer views clear after reset
    for (int k = 0; k < 32; k++) rd_reg("R1 reset reg", 5'(k), 8'h00);
    for (int p = 0; p < 3; p++) rd_ptr("R1 reset ptr", 2'(p), 16'h0000);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [7:0]  sel;
      logic [15:0] dat, exp;
      {op, sel, dat, exp} = VEC[i];
      case (op)
        OP_WR: begin wr_en = 1; wr_sel = sel[4:0]; wr_data = dat[7:0]; tick(); end
        OP_RD: begin rd_reg("R2/R3/R4/R7 table read", sel[4:0], exp[7:0]); tick(); end
        OP_IW: begin imm_we = 1; imm_sel = sel[3:0]; imm_wdata = dat[7:0]; tick(); end
        OP_IR: begin imm_sel = sel[3:0]; #1; chk("R3 imm read", {8'h00, imm_rdata}, exp); tick(); end
        OP_DW: begin
          ds_en = 1; ds_we = 1; ds_addr = {8'h00, sel}; ds_wdata = dat[7:0]; #1;
          chk("R4/R5 ds write oow", {15'h0, ds_oow}, {15'h0, exp[8]}); tick();
        end
        OP_DR: begin
          ds_en = 1; ds_addr = {8'h00, sel}; #1;
          chk("R4/R5 ds read", {7'h00, ds_oow, ds_rdata}, exp); tick();
        end
        OP_PW: begin ptr_we = 1; ptr_sel = sel[1:0]; ptr_wdata = dat; tick(); end
        default: begin rd_ptr("R6/R7 ptr read", sel[1:0], exp); tick(); end
      endcase
    end

    // R5: high address also out of window
    ds_en = 1; ds_addr = 16'h8003; #1;
    chk("R5 high addr", {7'h00, ds_oow, ds_rdata}, 16'h0100); tick();
    // R6: code 3 view reads zero
    rd_ptr("R6 none view", 2'd3, 16'h0000); tick();

    // R2: no write-through in the write cycle
    wr_en = 1; wr_sel = 5'd7; wr_data = 8'h99; ra_sel = 5'd7; rb_sel = 5'd7; #1;
    chk("R2 no bypass", {8'h00, ra_data}, 16'h0000);
    tick();
    rd_reg("R2 next cycle", 5'd7, 8'h99); tick();

    // R8: post-increment with wrap
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'hFFFF; tick();
    upd_en = 1; upd_sel = 2'd2; upd_mode = 0; #1;
    chk("R8 postinc addr", upd_addr, 16'hFFFF); tick();
    rd_ptr("R8 wrap", 2'd2, 16'h0000); tick();
    upd_en = 1; upd_sel = 2'd2; upd_mode = 0; #1;
    chk("R8 postinc addr 0", upd_addr, 16'h0000); tick();
    rd_ptr("R8 stored", 2'd2, 16'h0001); tick();

    // R9: pre-decrement with wrap
    ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'h0000; tick();
    upd_en = 1; upd_sel = 2'd1; upd_mode = 1; #1;
    chk("R9 predec addr", upd_addr, 16'hFFFF); tick();
    rd_ptr("R9 wrap", 2'd1, 16'hFFFF); tick();
    upd_en = 1; upd_sel = 2'd1; upd_mode = 1; #1;
    chk("R9 predec addr 2", upd_addr, 16'hFFFE); tick();

    // R10: byte write beats pointer write for its byte only
    ptr_we = 1; ptr_sel = 2'd0; ptr_wdata = 16'hBEEF;
    wr_en = 1; wr_sel = 5'd26; wr_data = 8'h55; tick();
    rd_ptr("R10 reg beats ptr", 2'd0, 16'hBE55); tick();
    wr_en = 1; wr_sel = 5'd20; wr_data = 8'hA1;
    imm_we = 1; imm_sel = 4'd4; imm_wdata = 8'hB2; tick();
    rd_reg("R10 reg beats imm", 5'd20, 8'hA1); tick();
    imm_we = 1; imm_sel = 4'd5; imm_wdata = 8'h33;
    ds_en = 1; ds_we = 1; ds_addr = 16'h0015; ds_wdata = 8'h44; tick();
    rd_reg("R10 imm beats ds", 5'd21, 8'h33); tick();
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'h1111;
    ds_en = 1; ds_we = 1; ds_addr = 16'h001F; ds_wdata = 8'h99; tick();
    rd_ptr("R10 ds beats ptr", 2'd2, 16'h9911); tick();

    // R11: pointer write beats update; code 3 changes nothing
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'h4000;
    upd_en = 1; upd_sel = 2'd2; upd_mode = 0; #1;
    chk("R11 upd addr during write", upd_addr, 16'h9911); tick();
    rd_ptr("R11 write wins", 2'd2, 16'h4000); tick();
    ptr_we = 1; ptr_sel = 2'd3; ptr_wdata = 16'hDEAD;
    upd_en = 1; upd_sel = 2'd3; #1;
    chk("R11 none upd addr", upd_addr, 16'h0000); tick();
    rd_ptr("R11 X kept", 2'd0, 16'hBE55); tick();
    rd_ptr("R11 Y kept", 2'd1, 16'hFFFE); tick();
    rd_ptr("R11 Z kept", 2'd2, 16'h4000); tick();

    // R1: reset again mid-run
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    rd_reg("R1 re-reset reg", 5'd3, 8'h00);
    rd_ptr("R1 re-reset ptr", 2'd0, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule